// File: doc/BRIEF.md
# Submission Queue Fetch Engine

This block is the controller-side tracker for one circular command queue that lives in host memory. Software announces new work by writing a new tail index through a doorbell. The engine keeps its own head index. Whenever head and tail differ and its local command buffer has room, it fetches the slot at the head position. A slot is exactly 64 bytes.

Each fetch is a single read request on a plain memory-read port. The request address is the queue base plus the head index times 64. The memory then returns sixteen 32-bit beats in order. The engine assembles these beats into one 512-bit command and pushes it into a small local buffer. A downstream executor drains that buffer with a valid/ready handshake.

The head index is published on a port so it can be copied into completion entries. It advances as soon as a slot has been copied. It says nothing about whether that command has executed or completed.

Top module: `sq_fetch_engine`

## Requirements
- R1: After reset, `sq_head` is 0, the stored tail is 0, and `rd_req_valid`, `cmd_valid` and `db_err` are all low.
- R2: Every read request carries address `q_base + sq_head*64`. Each slot gets exactly one request. While `rd_req_ready` is low, a pending request keeps `rd_req_valid` high with an unchanged address.
- R3: `sq_head` advances by one in the cycle after the sixteenth response beat is accepted. From `QDEPTH-1` it wraps to 0.
- R4: The number of slots fetched after a doorbell equals `(tail - head) mod QDEPTH`. With head equal to tail the queue is empty and no request is issued.
- R5: A doorbell write with `db_tail < QDEPTH` replaces the stored tail. A write with `db_tail >= QDEPTH` leaves the tail unchanged and drives `db_err` high for exactly the following cycle.
- R6: Response beat k (counting from 0) lands at bits `[32k+31:32k]` of `cmd_data`. Commands leave the buffer in slot order.
- R7: While the local buffer holds `BUF_DEPTH` commands, no new request is issued. No slot is skipped or fetched twice across the stall.
- R8: The head advance depends only on fetching. It happens even while `cmd_ready` is low and the command has not been consumed.
- R9: A doorbell write in the same cycle as the last beat of a fetch takes effect along with that head advance. Fetching then continues up to the new tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_base | input | ADDR_W | Byte address of slot 0 of the queue |
| db_valid | input | 1 | Doorbell write strobe |
| db_tail | input | DB_W | New tail index written by the host |
| db_err | output | 1 | Pulses for one cycle after an out-of-range doorbell value |
| sq_head | output | log2(QDEPTH) | Current head index, for reporting to the host |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the slot being fetched |
| rd_rsp_valid | input | 1 | Response beat valid |
| rd_rsp_data | input | 32 | Response beat data |
| cmd_valid | output | 1 | A fetched command is available |
| cmd_ready | input | 1 | Executor takes the command |
| cmd_data | output | 512 | Fetched command, beat 0 in the low bits |

## Verification
The interesting collision is a host doorbell arriving in the same clock edge as the final response beat. At that edge the head advance and the tail replacement both update pointer state. The bench provokes this by waiting until the memory model presents beat fifteen of a slot and driving the doorbell in that same cycle. It judges the outcome by which slots are fetched afterwards and by the final head: the earlier slot must not be fetched again, and the slots up to the new tail must be fetched without a gap.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int unsigned SLOT_BYTES = 64;
  localparam int unsigned BEAT_W     = 32;
  localparam int unsigned BEATS      = SLOT_BYTES * 8 / BEAT_W;
  localparam int unsigned CMD_W      = BEATS * BEAT_W;
  localparam int unsigned SLOT_SHIFT = $clog2(SLOT_BYTES);

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_DATA = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/sq_ptr_track.sv
module sq_ptr_track #(
  parameter int QDEPTH = 8,
  parameter int DB_W   = 16,
  parameter int PTR_W  = $clog2(QDEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_valid,
  input  logic [DB_W-1:0]  db_tail,
  input  logic             head_adv,
  output logic [PTR_W-1:0] head,
  output logic             pending_nz,
  output logic             db_err
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(QDEPTH - 1);

  logic [PTR_W-1:0] tail_q, tail_d;
  logic [PTR_W-1:0] head_q, head_d;
  logic             err_q, err_d;
  logic             db_ok;
  logic [PTR_W:0]   pend_cnt;

  always_comb begin
    db_ok  = db_valid && (db_tail < DB_W'(QDEPTH));
    tail_d = db_ok ? db_tail[PTR_W-1:0] : tail_q;
    err_d  = db_valid && !db_ok;
    head_d = head_q;
    if (head_adv) begin
      head_d = (head_q == LAST) ? '0 : head_q + 1'b1;
    end
  end

  // outstanding slots, modulo queue size
  always_comb begin
    pend_cnt = {1'b0, tail_q} - {1'b0, head_q};
    if (tail_q < head_q) begin
      pend_cnt = pend_cnt + (PTR_W+1)'(QDEPTH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      head_q <= '0;
      err_q  <= 1'b0;
    end else begin
      tail_q <= tail_d;
      head_q <= head_d;
      err_q  <= err_d;
    end
  end

  assign head       = head_q;
  assign pending_nz = (pend_cnt != '0);
  assign db_err     = err_q;
endmodule

// File: rtl/sq_fetch_ctrl.sv
module sq_fetch_ctrl
  import sq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending_nz,
  input  logic              buf_full,
  input  logic [PTR_W-1:0]  head,
  input  logic [ADDR_W-1:0] q_base,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [BEAT_W-1:0] rd_rsp_data,
  output logic              push,
  output logic [CMD_W-1:0]  push_data
);
  localparam int BC_W = $clog2(BEATS);
  localparam logic [BC_W-1:0] LAST_BEAT = BC_W'(BEATS - 1);

  fetch_state_e      state_q, state_d;
  logic [BC_W-1:0]   beat_q, beat_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    addr_d  = addr_q;
    cmd_d   = cmd_q;
    push    = 1'b0;
    case (state_q)
      FS_IDLE: begin
        if (pending_nz && !buf_full) begin
          state_d = FS_REQ;
          addr_d  = q_base + (ADDR_W'(head) << SLOT_SHIFT);
        end
      end
      FS_REQ: begin
        if (rd_req_ready) begin
          state_d = FS_DATA;
          beat_d  = '0;
        end
      end
      FS_DATA: begin
        if (rd_rsp_valid) begin
          cmd_d[int'(beat_q)*BEAT_W +: BEAT_W] = rd_rsp_data;
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            push    = 1'b1;
            state_d = FS_IDLE;
          end
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      beat_q  <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      addr_q  <= addr_d;
    end
  end

  // assembly register: datapath only, no reset
  always_ff @(posedge clk) begin
    if (state_q == FS_DATA && rd_rsp_valid) begin
      cmd_q <= cmd_d;
    end
  end

  assign rd_req_valid = (state_q == FS_REQ);
  assign rd_req_addr  = addr_q;
  assign push_data    = cmd_d;
endmodule

// File: rtl/sq_cmd_fifo.sv
module sq_cmd_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? step(wr_q) : wr_q;
    rd_d  = pop  ? step(rd_q) : rd_q;
    cnt_d = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_q] <= push_data;
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_q];
  assign full      = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/sq_fetch_engine.sv
module sq_fetch_engine
  import sq_pkg::*;
#(
  parameter int QDEPTH    = 8,
  parameter int BUF_DEPTH = 2,
  parameter int ADDR_W    = 32,
  parameter int DB_W      = 16,
  localparam int PTR_W    = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] q_base,
  input  logic              db_valid,
  input  logic [DB_W-1:0]   db_tail,
  output logic              db_err,
  output logic [PTR_W-1:0]  sq_head,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [511:0]      cmd_data
);
  logic             pending_nz;
  logic             buf_full;
  logic             push;
  logic [CMD_W-1:0] push_data;

  sq_ptr_track #(.QDEPTH(QDEPTH), .DB_W(DB_W), .PTR_W(PTR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .db_valid   (db_valid),
    .db_tail    (db_tail),
    .head_adv   (push),
    .head       (sq_head),
    .pending_nz (pending_nz),
    .db_err     (db_err)
  );

  sq_fetch_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pending_nz   (pending_nz),
    .buf_full     (buf_full),
    .head         (sq_head),
    .q_base       (q_base),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .push         (push),
    .push_data    (push_data)
  );

  sq_cmd_fifo #(.DEPTH(BUF_DEPTH), .W(CMD_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (cmd_valid && cmd_ready),
    .out_valid (cmd_valid),
    .out_data  (cmd_data),
    .full      (buf_full)
  );
endmodule

// File: rtl/sq_fetch_engine_chk.sv
module sq_fetch_engine_chk #(
  parameter int QDEPTH = 8,
  parameter int ADDR_W = 32,
  parameter int DB_W   = 16,
  parameter int PTR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] q_base,
  input logic              db_valid,
  input logic [DB_W-1:0]   db_tail,
  input logic              db_err,
  input logic [PTR_W-1:0]  sq_head,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [511:0]      cmd_data,
  input logic              buf_full
);
  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R2
  req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr == q_base + (ADDR_W'(sq_head) << 6));

  // R3
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sq_head) |-> sq_head == nxt($past(sq_head)));

  // R3
  head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_head < PTR_W'(QDEPTH) || QDEPTH == (1 << PTR_W));

  // R5
  bad_db_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid && db_tail >= DB_W'(QDEPTH) |=> db_err);

  // R5
  good_db_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(db_valid && db_tail >= DB_W'(QDEPTH)) |=> !db_err);

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  // R7
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> !$past(buf_full));
endmodule

bind sq_fetch_engine sq_fetch_engine_chk #(
  .QDEPTH(QDEPTH), .ADDR_W(ADDR_W), .DB_W(DB_W), .PTR_W(PTR_W)
) u_chk (.*);

// File: tb/sq_fetch_engine_tb.sv
`timescale 1ns/1ps
module sq_fetch_engine_tb;
  localparam int QDEPTH = 8;
  localparam int BUF_DEPTH = 2;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  q_base = BASE;
  logic         db_valid = 1'b0;
  logic [15:0]  db_tail = '0;
  logic         db_err;
  logic [2:0]   sq_head;
  logic         rd_req_valid;
  logic         rd_req_ready = 1'b1;
  logic [31:0]  rd_req_addr;
  logic         rd_rsp_valid = 1'b0;
  logic [31:0]  rd_rsp_data = '0;
  logic         cmd_valid;
  logic         cmd_ready = 1'b1;
  logic [511:0] cmd_data;

  int checks = 0;
  int fails = 0;
  int slot_log [64];
  int n_pop = 0;
  logic [31:0] req_log [64];
  int n_req = 0;
  int beat_bad = 0;
  logic last_beat_now = 1'b0;

  always #10 clk = ~clk;

  sq_fetch_engine #(.QDEPTH(QDEPTH), .BUF_DEPTH(BUF_DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .q_base(q_base),
    .db_valid(db_valid), .db_tail(db_tail), .db_err(db_err), .sq_head(sq_head),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model: beat k of a slot returns its own byte address
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rd_req_valid && rd_req_ready) begin
        logic [31:0] a;
        a = rd_req_addr;
        if (n_req < 64) req_log[n_req] = a;
        n_req++;
        for (int k = 0; k < 16; k++) begin
          @(negedge clk);
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = a + 32'(k * 4);
          last_beat_now = (k == 15);
        end
        @(negedge clk);
        rd_rsp_valid = 1'b0;
        last_beat_now = 1'b0;
      end
    end
  end

  // consumer side log
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && cmd_valid && cmd_ready) begin
        if (n_pop < 64) slot_log[n_pop] = int'((cmd_data[31:0] - BASE) >> 6);
        n_pop++;
        for (int k = 0; k < 16; k++)
          if (cmd_data[k*32 +: 32] != cmd_data[31:0] + 32'(k * 4)) beat_bad++;
      end
    end
  end

  task automatic ring(input int t);
    @(negedge clk);
    db_valid = 1'b1;
    db_tail  = 16'(t);
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic wait_head(input int target, input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (int'(sq_head) == target) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_logs();
    n_pop = 0;
    n_req = 0;
    beat_bad = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(sq_head == 0, "R1", "head after reset", sq_head, 0);
    chk(!rd_req_valid && !cmd_valid, "R1", "req/cmd valid after reset",
        {rd_req_valid, cmd_valid}, 0);
    chk(!db_err, "R1", "db_err after reset", db_err, 0);
    repeat (20) @(negedge clk);
    chk(n_req == 0, "R4", "no fetch when empty", n_req, 0);
  endtask

  task automatic t_basic();
    clear_logs();
    ring(3);
    wait_head(3, 300);
    chk(sq_head == 3, "R3", "head after three", sq_head, 3);
    chk(n_req == 3, "R4", "requests for three", n_req, 3);
    for (int i = 0; i < 3; i++) begin
      chk(req_log[i] == BASE + 32'(i * 64), "R2", "request address",
          req_log[i], BASE + 32'(i * 64));
      chk(slot_log[i] == i, "R6", "slot order", slot_log[i], i);
    end
    chk(beat_bad == 0, "R6", "beat placement errors", beat_bad, 0);
  endtask

  task automatic t_same_tail();
    clear_logs();
    ring(3);
    repeat (40) @(negedge clk);
    chk(n_req == 0, "R4", "same tail adds nothing", n_req, 0);
  endtask

  task automatic t_bad_db();
    clear_logs();
    @(negedge clk);
    db_valid = 1'b1;
    db_tail  = 16'd9;
    @(negedge clk); #1;
    chk(db_err, "R5", "db_err pulse", db_err, 1);
    db_valid = 1'b0;
    @(negedge clk); #1;
    chk(!db_err, "R5", "db_err one cycle", db_err, 0);
    repeat (40) @(negedge clk);
    chk(n_req == 0 && sq_head == 3, "R5", "bad tail ignored", n_req, 0);
  endtask

  task automatic t_wrap();
    clear_logs();
    ring(1);
    wait_head(1, 800);
    chk(sq_head == 1, "R3", "head wraps to 1", sq_head, 1);
    chk(n_pop == 6, "R4", "wrapped distance", n_pop, 6);
    for (int i = 0; i < 6; i++)
      chk(slot_log[i] == (3 + i) % 8, "R3", "wrap slot order", slot_log[i], (3 + i) % 8);
  endtask

  task automatic t_full();
    clear_logs();
    cmd_ready = 1'b0;
    ring(5);
    repeat (200) @(negedge clk); #1;
    chk(n_req == BUF_DEPTH, "R7", "requests while full", n_req, BUF_DEPTH);
    chk(sq_head == 3, "R8", "head advanced unconsumed", sq_head, 3);
    chk(cmd_valid, "R8", "command waiting", cmd_valid, 1);
    cmd_ready = 1'b1;
    wait_head(5, 600);
    chk(n_pop == 4, "R7", "pops after stall", n_pop, 4);
    for (int i = 0; i < 4; i++)
      chk(slot_log[i] == 1 + i, "R7", "no skip or repeat", slot_log[i], 1 + i);
  endtask

  task automatic t_req_bp();
    clear_logs();
    rd_req_ready = 1'b0;
    ring(6);
    repeat (20) @(negedge clk); #1;
    chk(rd_req_valid, "R2", "request held", rd_req_valid, 1);
    chk(rd_req_addr == BASE + 32'(5 * 64), "R2", "held address", rd_req_addr, BASE + 32'(5 * 64));
    chk(sq_head == 5, "R2", "no advance while held", sq_head, 5);
    rd_req_ready = 1'b1;
    wait_head(6, 300);
    chk(n_req == 1 && n_pop == 1, "R2", "one request per slot", n_req, 1);
  endtask

  task automatic t_coincide();
    clear_logs();
    ring(7);
    wait (last_beat_now);
    db_valid = 1'b1;
    db_tail  = 16'd1;
    @(negedge clk);
    db_valid = 1'b0;
    wait_head(1, 800);
    chk(sq_head == 1, "R9", "head after coincident doorbell", sq_head, 1);
    chk(n_pop == 3, "R9", "slots fetched", n_pop, 3);
    chk(slot_log[0] == 6 && slot_log[1] == 7 && slot_log[2] == 0, "R9", "slot sequence",
        slot_log[2], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_same_tail();
    t_bad_db();
    t_wrap();
    t_full();
    t_req_bp();
    t_coincide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule